// File: doc/BRIEF.md
# Nibble-wide accumulator processor core

This block is a small single-cycle processor that works on 4-bit data. It holds two working registers, an output register, a program counter and a one-bit carry flag. Each clock it fetches one 8-bit word from a 16-word program store, decodes it and commits its result on the rising edge. The upper nibble of the word selects the operation and the lower nibble is an immediate value.

All data movement goes through one 4-bit adder. The first operand is a selected source: register A, register B, the input port or zero. The second operand is either the immediate or zero. A plain move adds zero. A load of an immediate adds the immediate to zero. A jump takes its target from the same adder.

A conditional jump branches only when the carry left by the previous instruction is clear, so an add-and-branch loop can count until the adder overflows. The program store is filled through a simple write port, normally while reset is held. The program counter, the fetched word and the adder result are brought out for observation.

Top module: `nib_cpu`

## Requirements
- R1: While rst_n is low at a rising edge, the program counter, A, B, the output register and the carry flag all become 0. After such an edge the outputs show pc_dbg = 0 and out_port = 0.
- R2: When the executed instruction is not a taken jump, the program counter advances by one on the rising edge and wraps from 15 to 0.
- R3: opcode_dbg shows the stored program word at the current program counter, combinationally. Bits 7:4 of that word are the opcode and bits 3:0 are the immediate. alu_dbg shows, combinationally, the 4-bit sum of the selected source and the selected addend for that word, so a load of an immediate shows the immediate.
- R4: Opcodes that write A: 0000 gives A = A + imm, 0001 gives A = B, 0010 gives A = in_port, and 0011 gives A = imm. The sum is kept modulo 16.
- R5: Opcodes that write B: 0100 gives B = A, 0101 gives B = B + imm, 0110 gives B = in_port, and 0111 gives B = imm. The sum is kept modulo 16.
- R6: Opcode 1001 loads the output register with B, and opcode 1011 loads it with imm. out_port shows the new value from the rising edge that executes the instruction. No other opcode changes out_port.
- R7: Opcode 1111 loads the program counter with imm. A jump to its own address holds the program counter there.
- R8: Opcode 1110 loads the program counter with imm when the carry flag is 0. When the carry flag is 1, it advances the program counter by one instead.
- R9: Every defined opcode sets the carry flag to the adder's carry-out. Only 0000 and 0101 can produce a carry of 1; the moves, loads, output writes and jumps leave the carry at 0.
- R10: Opcodes 1000, 1010, 1100 and 1101 change none of A, B, the output register or the carry flag. They only advance the program counter, and alu_dbg shows 0 while one of them is fetched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_port | input | 4 | Data input, read by the input opcodes |
| prog_we | input | 1 | Program store write enable |
| prog_addr | input | 4 | Program store write address |
| prog_data | input | 8 | Program word to write |
| out_port | output | 4 | Output register value |
| pc_dbg | output | 4 | Current program counter |
| opcode_dbg | output | 8 | Program word at the current program counter |
| alu_dbg | output | 4 | Adder result for the current word |

## Verification
pc_dbg, opcode_dbg and alu_dbg belong to the word being fetched. opcode_dbg and alu_dbg are combinational, so they are compared in the same cycle that the fetch and the input port value are presented. The effects of an instruction appear one rising edge after it is fetched: the new out_port, the next program counter, and the register and carry updates, which become visible through later adder results and branch outcomes. The bench therefore drives inputs on the falling edge, checks shortly after it, and only then steps its behavioural model by one instruction, so every comparison falls at the point one register stage after its cause.

// File: rtl/nib_cpu_pkg.sv
// Package nib_cpu_pkg
// Purpose : shared control types for the nibble processor.
// Assumes : the opcode field is always 4 bits wide.
package nib_cpu_pkg;

    typedef enum logic [1:0] {
        SRC_A    = 2'd0,
        SRC_B    = 2'd1,
        SRC_IN   = 2'd2,
        SRC_ZERO = 2'd3
    } src_sel_e;

    typedef enum logic [2:0] {
        DST_NONE = 3'd0,
        DST_A    = 3'd1,
        DST_B    = 3'd2,
        DST_OUT  = 3'd3,
        DST_PC   = 3'd4
    } dst_sel_e;

    typedef struct packed {
        src_sel_e src;      // first adder operand
        logic     add_imm;  // second operand is the immediate (else zero)
        dst_sel_e dst;      // register written by the result
        logic     on_nc;    // PC write only when carry is clear
        logic     valid;    // defined opcode: carry is rewritten
    } ctrl_t;

endpackage

// File: rtl/nib_cpu_decode.sv
// Module nib_cpu_decode
// Purpose : maps a 4-bit opcode to operand, destination and branch controls.
// Assumes : purely combinational; undefined opcodes decode to a no-write
//           entry with a zero+zero addition.
module nib_cpu_decode
    import nib_cpu_pkg::*;
(
    input  logic [3:0] opcode,
    output ctrl_t      ctrl
);

    // Opcode table.
    always_comb begin
        ctrl = '{src: SRC_ZERO, add_imm: 1'b0, dst: DST_NONE, on_nc: 1'b0, valid: 1'b0};
        case (opcode)
            4'b0000: ctrl = '{src: SRC_A,    add_imm: 1'b1, dst: DST_A,   on_nc: 1'b0, valid: 1'b1};
            4'b0001: ctrl = '{src: SRC_B,    add_imm: 1'b0, dst: DST_A,   on_nc: 1'b0, valid: 1'b1};
            4'b0010: ctrl = '{src: SRC_IN,   add_imm: 1'b0, dst: DST_A,   on_nc: 1'b0, valid: 1'b1};
            4'b0011: ctrl = '{src: SRC_ZERO, add_imm: 1'b1, dst: DST_A,   on_nc: 1'b0, valid: 1'b1};
            4'b0100: ctrl = '{src: SRC_A,    add_imm: 1'b0, dst: DST_B,   on_nc: 1'b0, valid: 1'b1};
            4'b0101: ctrl = '{src: SRC_B,    add_imm: 1'b1, dst: DST_B,   on_nc: 1'b0, valid: 1'b1};
            4'b0110: ctrl = '{src: SRC_IN,   add_imm: 1'b0, dst: DST_B,   on_nc: 1'b0, valid: 1'b1};
            4'b0111: ctrl = '{src: SRC_ZERO, add_imm: 1'b1, dst: DST_B,   on_nc: 1'b0, valid: 1'b1};
            4'b1001: ctrl = '{src: SRC_B,    add_imm: 1'b0, dst: DST_OUT, on_nc: 1'b0, valid: 1'b1};
            4'b1011: ctrl = '{src: SRC_ZERO, add_imm: 1'b1, dst: DST_OUT, on_nc: 1'b0, valid: 1'b1};
            4'b1110: ctrl = '{src: SRC_ZERO, add_imm: 1'b1, dst: DST_PC,  on_nc: 1'b1, valid: 1'b1};
            4'b1111: ctrl = '{src: SRC_ZERO, add_imm: 1'b1, dst: DST_PC,  on_nc: 1'b0, valid: 1'b1};
            default: ;
        endcase
    end

endmodule

// File: rtl/nib_cpu_adder.sv
// Module nib_cpu_adder
// Purpose : the single W-bit adder every instruction passes through.
// Assumes : unsigned operands; carry-out is the bit above the sum.
module nib_cpu_adder #(
    parameter int W = 4
) (
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] sum,
    output logic         carry
);

    // Full-width add with carry out.
    always_comb begin
        {carry, sum} = {1'b0, op_a} + {1'b0, op_b};
    end

endmodule

// File: rtl/nib_cpu_progmem.sv
// Module nib_cpu_progmem
// Purpose : 2**AW-word program store with a synchronous write port and an
//           asynchronous read port addressed by the program counter.
// Assumes : contents are undefined until written; no reset of the array.
module nib_cpu_progmem #(
    parameter int AW = 4,
    parameter int DW = 8,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] words [DEPTH];

    // Program load write.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            words[wr_addr] <= wr_data;
        end
    end

    // Fetch read.
    assign rd_data = words[rd_addr];

endmodule

// File: rtl/nib_cpu.sv
// Module nib_cpu
// Purpose : single-cycle W-bit processor with registers A, B, an output
//           register, a program counter and a carry flag. Each cycle one
//           word is fetched, decoded and routed through one adder.
// Assumes : synchronous active-low reset; the program store is loaded
//           through prog_* before reset is released.
module nib_cpu
    import nib_cpu_pkg::*;
#(
    parameter int W = 4,
    localparam int IW = W + 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  in_port,
    input  logic          prog_we,
    input  logic [W-1:0]  prog_addr,
    input  logic [IW-1:0] prog_data,
    output logic [W-1:0]  out_port,
    output logic [W-1:0]  pc_dbg,
    output logic [IW-1:0] opcode_dbg,
    output logic [W-1:0]  alu_dbg
);

    logic [W-1:0]  pc_q;
    logic [W-1:0]  reg_a_q;
    logic [W-1:0]  reg_b_q;
    logic [W-1:0]  out_q;
    logic          carry_q;
    logic [IW-1:0] instr_word;
    logic [W-1:0]  imm;
    ctrl_t         ctrl;
    logic [W-1:0]  operand_src;
    logic [W-1:0]  operand_add;
    logic [W-1:0]  sum;
    logic          sum_carry;
    logic          take_pc;

    nib_cpu_progmem #(.AW(W), .DW(IW)) u_mem (
        .clk     (clk),
        .wr_en   (prog_we),
        .wr_addr (prog_addr),
        .wr_data (prog_data),
        .rd_addr (pc_q),
        .rd_data (instr_word)
    );

    nib_cpu_decode u_dec (
        .opcode (instr_word[IW-1:W]),
        .ctrl   (ctrl)
    );

    assign imm = instr_word[W-1:0];

    // Source operand select.
    always_comb begin
        case (ctrl.src)
            SRC_A:   operand_src = reg_a_q;
            SRC_B:   operand_src = reg_b_q;
            SRC_IN:  operand_src = in_port;
            default: operand_src = '0;
        endcase
    end

    // Addend select: immediate or zero.
    assign operand_add = ctrl.add_imm ? imm : '0;

    nib_cpu_adder #(.W(W)) u_add (
        .op_a  (operand_src),
        .op_b  (operand_add),
        .sum   (sum),
        .carry (sum_carry)
    );

    // Branch decision: PC destination, gated by carry for the conditional form.
    assign take_pc = (ctrl.dst == DST_PC) && !(ctrl.on_nc && carry_q);

    // Program counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else if (take_pc) begin
            pc_q <= sum;
        end else begin
            pc_q <= pc_q + 1'b1;
        end
    end

    // Data register and carry update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_a_q <= '0;
            reg_b_q <= '0;
            out_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            if (ctrl.dst == DST_A)   reg_a_q <= sum;
            if (ctrl.dst == DST_B)   reg_b_q <= sum;
            if (ctrl.dst == DST_OUT) out_q   <= sum;
            if (ctrl.valid)          carry_q <= sum_carry;
        end
    end

    assign out_port   = out_q;
    assign pc_dbg     = pc_q;
    assign opcode_dbg = instr_word;
    assign alu_dbg    = sum;

endmodule

// File: rtl/nib_cpu_checker.sv
// Module nib_cpu_checker
// Purpose : temporal properties on the processor's fetch word, program
//           counter, output register and carry flag.
// Assumes : attached to nib_cpu by the bind below.
module nib_cpu_checker #(
    parameter int W = 4,
    localparam int IW = W + 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [W-1:0]  pc,
    input logic [IW-1:0] instr,
    input logic [W-1:0]  out_port,
    input logic          carry
);

    logic [3:0]   op;
    logic [W-1:0] im;
    logic         is_undef;
    logic         is_jump;

    assign op       = instr[IW-1:W];
    assign im       = instr[W-1:0];
    assign is_undef = (op == 4'b1000) || (op == 4'b1010) || (op == 4'b1100) || (op == 4'b1101);
    assign is_jump  = (op == 4'b1110) || (op == 4'b1111);

    // R1: reset clears the PC and the output register.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (pc == '0) && (out_port == '0));

    // R2: the PC advances by one for every non-jump opcode.
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !is_jump |=> pc == ($past(pc) + 1'b1));

    // R6: the immediate output write appears on the port after the edge.
    assert_out_imm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'b1011) |=> out_port == $past(im));

    // R6: opcodes that are not output writes keep the port.
    assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((op != 4'b1001) && (op != 4'b1011)) |=> $stable(out_port));

    // R7: the unconditional jump loads the immediate.
    assert_jump_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 4'b1111) |=> pc == $past(im));

    // R8: the conditional jump is taken on a clear carry.
    assert_jnc_taken_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == 4'b1110) && !carry) |=> pc == $past(im));

    // R8: the conditional jump falls through on a set carry.
    assert_jnc_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((op == 4'b1110) && carry) |=> pc == ($past(pc) + 1'b1));

    // R9: jumps always leave the carry clear.
    assert_jump_clears_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        is_jump |=> !carry);

    // R10: undefined opcodes keep the carry flag.
    assert_undef_carry_R10: assert property (@(posedge clk) disable iff (!rst_n)
        is_undef |=> $stable(carry));

endmodule

bind nib_cpu nib_cpu_checker #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc       (pc_q),
    .instr    (instr_word),
    .out_port (out_q),
    .carry    (carry_q)
);

// File: tb/nib_cpu_test.sv
module nib_cpu_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] in_port = 4'd0;
    logic       prog_we = 1'b0;
    logic [3:0] prog_addr = 4'd0;
    logic [7:0] prog_data = 8'd0;
    logic [3:0] out_port;
    logic [3:0] pc_dbg;
    logic [7:0] opcode_dbg;
    logic [3:0] alu_dbg;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // Behavioural reference state.
    logic [7:0] mem [16];
    int m_pc, m_a, m_b, m_out, m_c;
    int last_op;

    nib_cpu uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_port    (in_port),
        .prog_we    (prog_we),
        .prog_addr  (prog_addr),
        .prog_data  (prog_data),
        .out_port   (out_port),
        .pc_dbg     (pc_dbg),
        .opcode_dbg (opcode_dbg),
        .alu_dbg    (alu_dbg)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, actual %0d cycles expected < 20000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int op);
        if (op < 0)                   return "R1";
        if (op <= 3)                  return "R4";
        if (op <= 7)                  return "R5";
        if (op == 9 || op == 11)      return "R6";
        if (op == 14)                 return "R8 R9";
        if (op == 15)                 return "R7";
        return "R10";
    endfunction

    function automatic int is_defined(input int op);
        return (op == 8 || op == 10 || op == 12 || op == 13) ? 0 : 1;
    endfunction

    // Model adder result (5 bits: carry in bit 4) for the current word.
    function automatic int model_sum(input int word, input int inv);
        int op, im;
        op = word >> 4;
        im = word & 15;
        case (op)
            0:  return m_a + im;
            1:  return m_b;
            2:  return inv;
            3:  return im;
            4:  return m_a;
            5:  return m_b + im;
            6:  return inv;
            7:  return im;
            9:  return m_b;
            11: return im;
            14: return im;
            15: return im;
            default: return 0;
        endcase
    endfunction

    // Advance the model by one executed instruction.
    task automatic model_step(input int inv);
        int word, op, s, nxt;
        word = mem[m_pc];
        op   = word >> 4;
        s    = model_sum(word, inv);
        nxt  = (m_pc + 1) & 15;
        if (op <= 3)                   m_a = s & 15;
        else if (op <= 7)              m_b = s & 15;
        else if (op == 9 || op == 11)  m_out = s & 15;
        else if (op == 15)             nxt = s & 15;
        else if (op == 14 && m_c == 0) nxt = s & 15;
        if (is_defined(op) != 0) m_c = (s >> 4) & 1;
        m_pc    = nxt;
        last_op = op;
    endtask

    // One cycle: drive input at the falling edge, compare, step the model.
    task automatic run_cycle(input logic [3:0] inv);
        string t;
        in_port = inv;
        #1;
        t = tag_of(last_op);
        check(t,    "pc_dbg",     int'(pc_dbg),     m_pc);
        check("R3", "opcode_dbg", int'(opcode_dbg), int'(mem[m_pc]));
        check("R3", "alu_dbg",    int'(alu_dbg),    model_sum(mem[m_pc], inv) & 15);
        check(t,    "out_port",   int'(out_port),   m_out);
        model_step(inv);
        @(negedge clk);
    endtask

    // Load a program under reset, check the reset state, release reset.
    task automatic load_and_reset();
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            prog_we   = 1'b1;
            prog_addr = 4'(i);
            prog_data = mem[i];
            @(negedge clk);
        end
        prog_we = 1'b0;
        @(negedge clk);
        #1;
        check("R1", "pc after reset",  int'(pc_dbg),   0);
        check("R1", "out after reset", int'(out_port), 0);
        m_pc = 0; m_a = 0; m_b = 0; m_out = 0; m_c = 0;
        last_op = -1;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    logic [3:0] seen [16];
    int seq [9] = '{3, 6, 12, 8, 8, 12, 6, 3, 1};
    int saw_taken, saw_fall;

    initial begin
        // Program 1: output pattern, then a jump to itself.
        foreach (seq[i]) mem[i] = 8'hB0 | 8'(seq[i]);
        mem[9] = 8'hF9;
        for (int i = 10; i < 16; i++) mem[i] = 8'h00;
        load_and_reset();
        for (int k = 0; k < 16; k++) begin
            seen[k] = out_port;
            run_cycle(4'(k));
        end
        for (int k = 0; k < 9; k++)
            check("R6", "output pattern", int'(seen[k + 1]), seq[k]);
        check("R7", "spin on self jump", int'(pc_dbg), 9);

        // Program 2: count to carry with the conditional jump, then moves.
        mem[0]  = 8'h3D;  // A = 13
        mem[1]  = 8'h01;  // A = A + 1
        mem[2]  = 8'hE1;  // jump to 1 if no carry
        mem[3]  = 8'h20;  // A = in
        mem[4]  = 8'h60;  // B = in
        mem[5]  = 8'h59;  // B = B + 9
        mem[6]  = 8'h10;  // A = B
        mem[7]  = 8'h40;  // B = A
        mem[8]  = 8'h90;  // out = B
        mem[9]  = 8'h85;  // undefined
        mem[10] = 8'hC3;  // undefined
        mem[11] = 8'h72;  // B = 2
        mem[12] = 8'h90;  // out = B
        mem[13] = 8'hA5;  // undefined
        mem[14] = 8'hD0;  // undefined
        mem[15] = 8'hFF;  // jump to self
        load_and_reset();
        saw_taken = 0;
        saw_fall  = 0;
        for (int k = 0; k < 40; k++) begin
            if (m_pc == 2 && m_c == 0) saw_taken++;
            if (m_pc == 2 && m_c == 1) saw_fall++;
            run_cycle(4'((k * 7 + 3) & 15));
        end
        check("R8", "conditional jumps taken", saw_taken, 2);
        check("R8", "conditional jumps not taken", saw_fall, 1);
        check("R7", "final spin address", int'(pc_dbg), 15);

        // Program 3: repeated increments wrap the PC and roll the carry.
        for (int i = 0; i < 16; i++) mem[i] = (i == 7) ? 8'hE9 : ((i == 12) ? 8'h97 : 8'h53);
        load_and_reset();
        for (int k = 0; k < 60; k++) run_cycle(4'(k & 15));
        check("R2", "pc after wrap run", int'(pc_dbg), m_pc);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule